// File: doc/BRIEF.md
# Result Output Port with Selectable Coding

This block sits between a converter's result path and a shared 8-bit processor bus. When the conversion finishes, a one-cycle latch strobe captures the 18-bit raw result, which arrives in offset-binary form. In the same cycle the block recodes the word into one of five output formats, chosen by a mode input that is sampled at that edge. The coded word is held until the next strobe. Reads never change it.

The held word leaves the block through three slices of uneven width. An upper slice of 8 bits carries the MSB end, a middle slice carries the next 8 bits, and a lower slice carries the last 2 bits. Each slice has its own active-low enable, and the enables are independent, so a narrow bus can collect the word in three reads. Any set of slices can also be enabled together. Each tri-state line is modelled as a data bit with its own output-enable bit. A line that is not driven shows data 0 with enable 0.

A small two-state machine tracks the held word. In `ST_EMPTY`, after reset and before any capture, the held word is all zeros. The transition `load` (strobe while empty) moves to `ST_HELD`. In `ST_HELD`, the transition `reload` (strobe while held) stays in `ST_HELD` and replaces the word. With no strobe, either state holds.

Top module: `res_bus_port`

## Requirements
- R1: After reset the held word is all zeros, so enabling every slice shows 18'h00000 with every output-enable bit set.
- R2: A high `latch_i` at a rising clock edge captures the coded form of `raw_i`, and the new word is on the bus after that edge.
- R3: Without a strobe the held word does not change, whatever happens on `raw_i`, `mode_i` or the enables.
- R4: `mode_i` takes effect only at a strobe edge, so a change between strobes alters nothing until the next capture.
- R5: Mode 3'd0 (offset binary) passes the raw word unchanged: bipolar zero is 18'h20000.
- R6: Mode 3'd1 (complementary offset binary) inverts every bit, so raw full scale 18'h3FFFF gives 18'h00000 and raw 18'h20000 gives 18'h1FFFF.
- R7: Mode 3'd2 (two's complement) inverts only bit 17, so raw 18'h20000 gives 18'h00000 and raw 18'h00000 gives 18'h20000.
- R8: Mode 3'd3 (straight binary, for unipolar ranges) passes the raw word; mode 3'd4 (complementary binary) inverts every bit; modes 3'd5 to 3'd7 behave as mode 3'd0.
- R9: `hi_en_n` low drives bus bits 17:10 (the MSB end) with their output-enable bits set.
- R10: `mid_en_n` low drives bus bits 9:2 with their output-enable bits set.
- R11: `lo_en_n` low drives bus bits 1:0 (the LSB end) with their output-enable bits set.
- R12: Every bit of a slice whose enable is high has output-enable 0 and data 0.
- R13: The enables act independently; any combination, including all three at once, drives exactly the selected slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_i | input | 18 | Raw offset-binary result |
| latch_i | input | 1 | Capture strobe at end of conversion |
| mode_i | input | 3 | Output coding select, sampled at capture |
| hi_en_n | input | 1 | Active-low enable, bits 17:10 |
| mid_en_n | input | 1 | Active-low enable, bits 9:2 |
| lo_en_n | input | 1 | Active-low enable, bits 1:0 |
| bus_q | output | 18 | Bus data (0 where not driven) |
| bus_oe | output | 18 | Per-bit output enable |

## Verification
The assertions check four rules on every cycle:
- The held word never moves without a strobe.
- The word stays zero while the machine is empty.
- The complementary and two's-complement captures relate correctly to the raw word of the previous cycle.
- A disabled slice never asserts its output-enable bits.

The bench scenarios cover what only a chosen stimulus can show:
- the specific code values at the zero and full-scale points in each mode;
- reserved modes;
- a mode change that must wait for the next strobe;
- the placement of each slice on the bus under every enable combination.

// File: rtl/outport_pkg.sv
package outport_pkg;

    typedef enum logic [2:0] {
        CODE_OFFBIN  = 3'd0,
        CODE_COFFBIN = 3'd1,
        CODE_TWOS    = 3'd2,
        CODE_BIN     = 3'd3,
        CODE_CBIN    = 3'd4
    } code_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } hold_state_e;

    localparam int NUM_SLICES = 3;

endpackage

// File: rtl/res_coder.sv
module res_coder
    import outport_pkg::*;
#(
    parameter int W = 18
) (
    input  logic [W-1:0] raw_i,
    input  logic [2:0]   mode_i,
    output logic [W-1:0] coded_o
);

    code_mode_e mode_e;
    assign mode_e = code_mode_e'(mode_i);

    always_comb begin
        unique case (mode_e)
            CODE_COFFBIN,
            CODE_CBIN:    coded_o = ~raw_i;
            CODE_TWOS:    coded_o = {~raw_i[W-1], raw_i[W-2:0]};
            CODE_OFFBIN,
            CODE_BIN:     coded_o = raw_i;
            default:      coded_o = raw_i;
        endcase
    end

endmodule

// File: rtl/res_hold.sv
module res_hold
    import outport_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] coded_i,
    output logic [W-1:0] held_o
);

    hold_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: load (EMPTY->HELD), reload (HELD->HELD)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (load_i) state_d = ST_HELD;
            ST_HELD:  state_d = ST_HELD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // output process: held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_o <= '0;
        else if (load_i) held_o <= coded_i;
    end

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(held_o));

    assert_empty_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (held_o == '0));

endmodule

// File: rtl/bus_slice.sv
module bus_slice #(
    parameter int W = 8
) (
    input  logic         en_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] oe_o
);

    always_comb begin
        oe_o = {W{~en_n}};
        q_o  = d_i & oe_o;
    end

endmodule

// File: rtl/res_bus_port.sv
module res_bus_port
    import outport_pkg::*;
#(
    parameter int RES_W = 18,
    parameter int HI_W  = 8,
    parameter int MID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] raw_i,
    input  logic             latch_i,
    input  logic [2:0]       mode_i,
    input  logic             hi_en_n,
    input  logic             mid_en_n,
    input  logic             lo_en_n,
    output logic [RES_W-1:0] bus_q,
    output logic [RES_W-1:0] bus_oe
);

    localparam int LO_W   = RES_W - HI_W - MID_W;
    localparam int MID_LO = LO_W;
    localparam int HI_LO  = LO_W + MID_W;

    logic [RES_W-1:0]      coded_w;
    logic [RES_W-1:0]      held_w;
    logic [NUM_SLICES-1:0] en_n_v;

    assign en_n_v = {hi_en_n, mid_en_n, lo_en_n};

    res_coder #(.W(RES_W)) u_coder (
        .raw_i   (raw_i),
        .mode_i  (mode_i),
        .coded_o (coded_w)
    );

    res_hold #(.W(RES_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (latch_i),
        .coded_i (coded_w),
        .held_o  (held_w)
    );

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int SW  = (i == 2) ? HI_W  : ((i == 1) ? MID_W  : LO_W);
        localparam int SLO = (i == 2) ? HI_LO : ((i == 1) ? MID_LO : 0);
        bus_slice #(.W(SW)) u_slice (
            .en_n (en_n_v[i]),
            .d_i  (held_w[SLO +: SW]),
            .q_o  (bus_q[SLO +: SW]),
            .oe_o (bus_oe[SLO +: SW])
        );
    end

    assert_coff_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && mode_i == 3'd1) |=> (held_w == ~$past(raw_i)));

    assert_twos_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && mode_i == 3'd2) |=>
            (held_w == {~$past(raw_i[RES_W-1]), $past(raw_i[RES_W-2:0])}));

    assert_hi_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en_n |-> (bus_oe[HI_LO +: HI_W] == '0));

    assert_lo_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en_n |-> (bus_oe[0 +: LO_W] == '0));

endmodule

// File: tb/tb_res_bus_port.sv
module tb_res_bus_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] raw_i = '0;
    logic        latch_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic        hi_en_n = 1'b1, mid_en_n = 1'b1, lo_en_n = 1'b1;
    logic [17:0] bus_q, bus_oe;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    res_bus_port dut (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .latch_i(latch_i),
        .mode_i(mode_i), .hi_en_n(hi_en_n), .mid_en_n(mid_en_n),
        .lo_en_n(lo_en_n), .bus_q(bus_q), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", tag, got, exp);
        end
    endtask

    task automatic set_en(input logic h, input logic m, input logic l);
        hi_en_n = h; mid_en_n = m; lo_en_n = l;
        #1;
    endtask

    task automatic capture(input logic [17:0] r, input logic [2:0] m);
        @(negedge clk);
        raw_i = r; mode_i = m; latch_i = 1'b1;
        @(negedge clk);
        latch_i = 1'b0;
    endtask

    task automatic read_all(input string tag, input logic [17:0] exp);
        set_en(1'b0, 1'b0, 1'b0);
        chk(tag, bus_q, exp);
        chk(tag, bus_oe, 18'h3FFFF);
        set_en(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 idle oe", bus_oe, 18'h00000);
        chk("R12 idle data", bus_q, 18'h00000);
        read_all("R1 reset word", 18'h00000);
    endtask

    task automatic t_offbin;
        capture(18'h20000, 3'd0); read_all("R5 R2 offbin zero", 18'h20000);
        capture(18'h2A5C3, 3'd0); read_all("R5 offbin pattern", 18'h2A5C3);
    endtask

    task automatic t_coffbin;
        capture(18'h3FFFF, 3'd1); read_all("R6 coff fullscale", 18'h00000);
        capture(18'h20000, 3'd1); read_all("R6 coff zero", 18'h1FFFF);
    endtask

    task automatic t_twos;
        capture(18'h20000, 3'd2); read_all("R7 twos zero", 18'h00000);
        capture(18'h00000, 3'd2); read_all("R7 twos negfs", 18'h20000);
        capture(18'h3FFFF, 3'd2); read_all("R7 twos posfs", 18'h1FFFF);
    endtask

    task automatic t_binary;
        capture(18'h12345, 3'd3); read_all("R8 straight bin", 18'h12345);
        capture(18'h12345, 3'd4); read_all("R8 comp bin", 18'h2DCBA);
        capture(18'h0F0F0, 3'd5); read_all("R8 reserved5", 18'h0F0F0);
        capture(18'h0F0F0, 3'd7); read_all("R8 reserved7", 18'h0F0F0);
    endtask

    task automatic t_mode_sampled;
        capture(18'h00FF0, 3'd0);
        @(negedge clk); mode_i = 3'd1; raw_i = 18'h3C3C3;
        repeat (3) @(negedge clk);
        read_all("R4 mode change no strobe", 18'h00FF0);
        capture(18'h00FF0, 3'd1);
        read_all("R4 mode used next strobe", 18'h3F00F);
    endtask

    task automatic t_hold;
        capture(18'h15A5A, 3'd0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            raw_i = 18'(k * 18'h0B3C1);
            mode_i = 3'(k);
            set_en(k[0], k[1], k[2]);
        end
        set_en(1'b1, 1'b1, 1'b1);
        read_all("R3 hold across activity", 18'h15A5A);
        read_all("R3 repeated read", 18'h15A5A);
    endtask

    task automatic t_slices;
        capture(18'h2B6D9, 3'd0);
        set_en(1'b0, 1'b1, 1'b1);
        chk("R9 hi data", bus_q, 18'h2B6D9 & 18'h3FC00);
        chk("R9 hi oe", bus_oe, 18'h3FC00);
        set_en(1'b1, 1'b0, 1'b1);
        chk("R10 mid data", bus_q, 18'h2B6D9 & 18'h003FC);
        chk("R10 mid oe", bus_oe, 18'h003FC);
        set_en(1'b1, 1'b1, 1'b0);
        chk("R11 lo data", bus_q, 18'h2B6D9 & 18'h00003);
        chk("R11 lo oe", bus_oe, 18'h00003);
        for (int c = 0; c < 8; c++) begin
            logic [17:0] m;
            m = (c[2] ? 18'h3FC00 : 18'h0) | (c[1] ? 18'h003FC : 18'h0)
              | (c[0] ? 18'h00003 : 18'h0);
            set_en(~c[2], ~c[1], ~c[0]);
            chk("R13 combo oe", bus_oe, m);
            chk("R12 R13 combo data", bus_q, 18'h2B6D9 & m);
        end
        set_en(1'b1, 1'b1, 1'b1);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offbin();
        t_coffbin();
        t_twos();
        t_binary();
        t_mode_sampled();
        t_hold();
        t_slices();
        finish_up();
    end

endmodule